// File: doc/BRIEF.md
# Serial SRAM Host Controller

This block is the host side of a four-wire serial bus to an external byte-wide static RAM. A client asks for one operation at a time: a memory read, a memory write, a status read or a status write. The block frames it on the wire as a command byte, a two-byte address for memory operations, and then a stream of data bytes. Write bytes come in through a valid/ready handshake. Read bytes go out as a one-cycle strobe with the byte beside it.

The serial clock is derived from the system clock by a fixed divider parameter. The bus idles low. Outgoing bits change only on falling edges, and incoming bits are taken on rising edges. A client pause input suspends the transfer through an active-low pause output to the slave. That output changes only while the serial clock is low, and no clock edges are produced while it is asserted. When the pause is released, the transfer continues from the bit where it stopped.

Top module: `sram_spi_host`

## Requirements
- R1: The first byte sent after chip select falls is the command. req_op 0 (memory read) sends 0x03, 1 (memory write) sends 0x02, 2 (status read) sends 0x05 and 3 (status write) sends 0x01. All bytes go MSB first.
- R2: For memory operations the command is followed by 16 address bits, MSB first. The top bit is always sent as 0 and the lower 15 bits equal req_addr[14:0].
- R3: spi_mosi changes only while spi_sck is low. spi_miso is sampled at each rising edge of spi_sck. During the data phase of a read, each received byte is presented on rd_data together with a one-cycle rd_valid pulse, in bus order.
- R4: Each half period of spi_sck lasts HALF_DIV system clocks when nothing stalls it. The first rising edge comes HALF_DIV clocks after chip select falls.
- R5: A memory operation moves req_len data bytes, and a req_len of 0 moves one byte. Write bytes are taken with wr_valid and wr_ready, and wr_ready is only high while busy. If the next write byte is not yet there, spi_sck is held high until it arrives.
- R6: A status write sends exactly one data byte with bits 5 to 1 forced to 0, so the byte sent is wr_data & 0xC1. A status read returns exactly one byte. req_len has no effect on either status operation.
- R7: spi_hold_n only changes while spi_sck is low, and it goes low only while pause_req is high. While it is low, spi_sck has no edges. The transfer then resumes without losing data.
- R8: Chip select stays low for the whole operation and rises only while spi_sck is low, HALF_DIV clocks after the last falling edge. It then stays high for at least 2*HALF_DIV clocks before the next operation. spi_sck is low whenever chip select is high.
- R9: busy equals the inverse of chip select. It is high from the clock edge that accepts the request until chip select rises. done is a one-cycle pulse in the cycle chip select rises, and req_ready is high only when no operation is in progress or finishing.
- R10: After reset spi_cs_n=1, spi_sck=0, spi_hold_n=1, busy=0, done=0, rd_valid=0, wr_ready=0 and req_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_op | input | 2 | 0 mem read, 1 mem write, 2 status read, 3 status write |
| req_addr | input | 16 | Start address (bit 15 not sent) |
| req_len | input | LEN_W | Data byte count for memory operations |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken when high together with wr_valid |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle strobe for a received byte |
| rd_data | output | 8 | Received byte |
| pause_req | input | 1 | Client request to suspend the bus |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave |
| spi_hold_n | output | 1 | Pause to slave, active low |

## Verification
The assertions assume that reset is applied before any request, and that the bench issues a new request only after done. They also assume that the slave model changes spi_miso only on falling edges of spi_sck. The bench toggles pause_req at random and throttles wr_valid at random, but it changes req_* only while req_valid is being presented and holds them until the request is accepted. Directed cases cover a status write of 0xFF, an address with bit 15 set, a zero length and a burst that crosses the top of the address space. A fixed seed drives a random mix of all four operations on top of these.

// File: rtl/sram_spi_host.sv
`timescale 1ns/1ps
module sram_spi_host #(
  parameter int HALF_DIV = 2,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  input  logic             pause_req,
  output logic             busy,
  output logic             done,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_hold_n
);
  localparam int DIV_W = $clog2(2 * HALF_DIV) + 1;
  localparam logic [DIV_W-1:0] HALF_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [DIV_W-1:0] GAP_LAST  = DIV_W'(2 * HALF_DIV - 1);
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_SRD = 2'd2, OP_SWR = 2'd3;
  localparam logic [7:0] SR_KEEP = 8'hC1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_END, ST_GAP} st_t;
  typedef enum logic [1:0] {PH_CMD, PH_AHI, PH_ALO, PH_DAT} ph_t;

  function automatic logic [7:0] cmd_of(input logic [1:0] op);
    case (op)
      OP_RD:   return 8'h03;
      OP_WR:   return 8'h02;
      OP_SRD:  return 8'h05;
      default: return 8'h01;
    endcase
  endfunction

  st_t              st_q;
  ph_t              ph_q;
  logic [1:0]       op_q;
  logic [15:0]      addr_q;
  logic [LEN_W-1:0] left_q, fetch_q, len_eff;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q, rx_q, wbuf_q, rdd_q, wbyte;
  logic             wbuf_v, sck_q, cs_n_q, hold_q, done_q, rdv_q;
  logic             is_wr, tick, last_data, need_w, fall_ok;

  assign is_wr     = (op_q == OP_WR) || (op_q == OP_SWR);
  assign tick      = (div_q == HALF_LAST);
  assign last_data = (left_q == LEN_W'(1));
  assign need_w    = (bit_q == 3'd7) &&
                     ((ph_q == PH_CMD && op_q == OP_SWR) ||
                      (ph_q == PH_ALO && op_q == OP_WR) ||
                      (ph_q == PH_DAT && op_q == OP_WR && !last_data));
  assign fall_ok   = !need_w || wbuf_v;
  assign wbyte     = (op_q == OP_SWR) ? (wbuf_q & SR_KEEP) : wbuf_q;
  assign len_eff   = (req_op[1] || req_len == '0) ? LEN_W'(1) : req_len;

  assign req_ready  = (st_q == ST_IDLE);
  assign wr_ready   = (st_q == ST_RUN) && is_wr && !wbuf_v && (fetch_q != '0);
  assign busy       = (st_q == ST_RUN) || (st_q == ST_END);
  assign done       = done_q;
  assign rd_valid   = rdv_q;
  assign rd_data    = rdd_q;
  assign spi_cs_n   = cs_n_q;
  assign spi_sck    = sck_q;
  assign spi_mosi   = sh_q[7];
  assign spi_hold_n = !hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_CMD;
      op_q    <= OP_RD;
      addr_q  <= '0;
      left_q  <= '0;
      fetch_q <= '0;
      div_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      rx_q    <= '0;
      wbuf_q  <= '0;
      rdd_q   <= '0;
      wbuf_v  <= 1'b0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      hold_q  <= 1'b0;
      done_q  <= 1'b0;
      rdv_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      if (wr_valid && wr_ready) begin
        wbuf_q  <= wr_data;
        wbuf_v  <= 1'b1;
        fetch_q <= fetch_q - LEN_W'(1);
      end
      case (st_q)
        ST_IDLE: if (req_valid) begin
          st_q    <= ST_RUN;
          cs_n_q  <= 1'b0;
          op_q    <= req_op;
          addr_q  <= req_addr;
          left_q  <= len_eff;
          fetch_q <= (req_op == OP_WR) ? len_eff : ((req_op == OP_SWR) ? LEN_W'(1) : '0);
          sh_q    <= cmd_of(req_op);
          ph_q    <= PH_CMD;
          bit_q   <= '0;
          div_q   <= '0;
        end
        ST_RUN: begin
          if (hold_q) begin
            if (!pause_req) begin
              hold_q <= 1'b0;
              div_q  <= '0;
            end
          end else if (!sck_q && pause_req) begin
            hold_q <= 1'b1;
          end else if (!tick) begin
            div_q <= div_q + DIV_W'(1);
          end else if (!sck_q) begin
            sck_q <= 1'b1;
            div_q <= '0;
            rx_q  <= {rx_q[6:0], spi_miso};
            if (ph_q == PH_DAT && !is_wr && bit_q == 3'd7) begin
              rdv_q <= 1'b1;
              rdd_q <= {rx_q[6:0], spi_miso};
            end
          end else if (fall_ok) begin
            sck_q <= 1'b0;
            div_q <= '0;
            if (bit_q != 3'd7) begin
              bit_q <= bit_q + 3'd1;
              sh_q  <= {sh_q[6:0], 1'b0};
            end else begin
              bit_q <= '0;
              case (ph_q)
                PH_CMD: if (op_q[1]) begin
                  ph_q <= PH_DAT;
                  sh_q <= is_wr ? wbyte : 8'h00;
                  if (is_wr) wbuf_v <= 1'b0;
                end else begin
                  ph_q <= PH_AHI;
                  sh_q <= addr_q[15:8] & 8'h7F;
                end
                PH_AHI: begin
                  ph_q <= PH_ALO;
                  sh_q <= addr_q[7:0];
                end
                PH_ALO: begin
                  ph_q <= PH_DAT;
                  sh_q <= is_wr ? wbyte : 8'h00;
                  if (is_wr) wbuf_v <= 1'b0;
                end
                default: if (last_data) begin
                  st_q <= ST_END;
                end else begin
                  left_q <= left_q - LEN_W'(1);
                  sh_q   <= is_wr ? wbyte : 8'h00;
                  if (is_wr) wbuf_v <= 1'b0;
                end
              endcase
            end
          end
        end
        ST_END: if (tick) begin
          cs_n_q <= 1'b1;
          st_q   <= ST_GAP;
          div_q  <= '0;
          done_q <= 1'b1;
        end else begin
          div_q <= div_q + DIV_W'(1);
        end
        default: if (div_q == GAP_LAST) begin
          st_q <= ST_IDLE;
        end else begin
          div_q <= div_q + DIV_W'(1);
        end
      endcase
    end
  end
endmodule

// File: rtl/sram_spi_host_chk.sv
`timescale 1ns/1ps
module sram_spi_host_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi,
  input logic spi_hold_n,
  input logic busy,
  input logic done,
  input logic wr_ready
);
  // R7
  hold_at_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_hold_n) |-> (!spi_sck && !$past(spi_sck)));
  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_hold_n && !$past(spi_hold_n)) |-> $stable(spi_sck));
  // R3
  mosi_high_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
  // R8
  cs_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> !spi_sck);
  // R8
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  // R9
  busy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !spi_cs_n);
  // R9
  done_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(spi_cs_n));
  // R5
  wr_ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> busy);
endmodule

bind sram_spi_host sram_spi_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
  .spi_mosi(spi_mosi), .spi_hold_n(spi_hold_n), .busy(busy), .done(done),
  .wr_ready(wr_ready)
);

// File: tb/tb_sram_spi_host.sv
`timescale 1ns/1ps
module tb_sram_spi_host;
  localparam int HD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0, req_ready, wr_valid = 1'b0, wr_ready, rd_valid;
  logic [1:0] req_op = 2'd0;
  logic [15:0] req_addr = '0, req_len = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic pause_req = 1'b0, busy, done;
  logic spi_cs_n, spi_sck, spi_mosi, spi_hold_n;
  logic miso_q = 1'b0;

  sram_spi_host #(.HALF_DIV(HD), .LEN_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .pause_req(pause_req),
    .busy(busy), .done(done), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(miso_q), .spi_hold_n(spi_hold_n)
  );

  int vectors = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_cmd(input logic [1:0] op);
    case (op)
      2'd0: return 8'h03;
      2'd1: return 8'h02;
      2'd2: return 8'h05;
      default: return 8'h01;
    endcase
  endfunction

  // slave model
  logic [7:0] mem [0:1023];
  logic [7:0] shadow [0:1023];
  logic [7:0] sreg = 8'h00, sreg_exp = 8'h00;
  logic [7:0] shin = '0, rdbyte = '0, cap_op = '0;
  logic [15:0] cap_addr = '0;
  logic [14:0] ptr = '0;
  int bitn = 0, nbytes = 0;

  function automatic int hdr_bits(input logic [7:0] o);
    return (o == 8'h05 || o == 8'h01) ? 8 : 24;
  endfunction

  always @(negedge spi_cs_n) begin bitn = 0; nbytes = 0; cap_op = '0; end

  always @(posedge spi_sck) if (!spi_cs_n && spi_hold_n) begin
    shin = {shin[6:0], spi_mosi};
    bitn++;
    if (bitn == 8) begin
      cap_op = shin;
      if (shin == 8'h05) rdbyte = sreg;
    end else if (bitn > hdr_bits(cap_op) && bitn % 8 == 0) begin
      nbytes++;
      case (cap_op)
        8'h02: begin mem[ptr[9:0]] = shin; ptr++; end
        8'h03: begin ptr++; rdbyte = mem[ptr[9:0]]; end
        8'h01: sreg = shin;
        default: ;
      endcase
    end else if (bitn == 16) begin
      cap_addr[15:8] = shin;
    end else if (bitn == 24) begin
      cap_addr[7:0] = shin;
      ptr = cap_addr[14:0];
      rdbyte = mem[ptr[9:0]];
    end
  end

  always @(negedge spi_sck)
    if (!spi_cs_n && spi_hold_n && (cap_op == 8'h03 || cap_op == 8'h05) && bitn >= hdr_bits(cap_op))
      miso_q = rdbyte[7 - ((bitn - hdr_bits(cap_op)) % 8)];

  int hold_edges = 0, holds = 0, hold_bad = 0;
  always @(posedge spi_sck or negedge spi_sck) if (spi_hold_n === 1'b0) hold_edges++;
  always @(spi_hold_n) begin
    if (spi_hold_n === 1'b0) holds++;
    if (spi_sck === 1'b1) hold_bad++;
  end

  // feeder, collector, pause driver, timing monitor
  logic [7:0] wq [0:63];
  logic [7:0] rq [0:63];
  int wn = 0, widx = 0, rn = 0;
  bit hs_prev = 0, throttle = 0, pause_en = 0;
  int cyc = 0, t_fall = 0, t_rise = 0, nrise = 0, first_dly = 0, first_hi = 0;
  int gap_cnt = 0, gap_bad = 0, done_bad = 0, busy_bad = 0;
  bit seen = 0, prev_cs = 1, prev_sck = 0;

  always @(negedge clk) begin
    if (hs_prev) widx++;
    wr_valid = (widx < wn) && (!throttle || ($urandom % 3 == 0));
    wr_data  = (widx < wn) ? wq[widx] : 8'h00;
    hs_prev  = wr_valid && wr_ready;
    if (rd_valid && rn < 64) begin rq[rn] = rd_data; rn++; end
    if (!pause_en) pause_req = 1'b0;
    else if (busy && ($urandom % 12 == 0)) pause_req = ~pause_req;
    if (rst_n) begin
      cyc++;
      if (prev_cs && !spi_cs_n) begin
        if (seen && gap_cnt < 2 * HD) gap_bad++;
        seen = 1; t_fall = cyc; nrise = 0;
      end
      gap_cnt = spi_cs_n ? gap_cnt + 1 : 0;
      if (!prev_sck && spi_sck) begin
        if (nrise == 0) first_dly = cyc - t_fall;
        t_rise = cyc; nrise++;
      end
      if (prev_sck && !spi_sck && nrise == 1) first_hi = cyc - t_rise;
      if (done && !(spi_cs_n && !prev_cs)) done_bad++;
      if (busy == spi_cs_n) busy_bad++;
      prev_cs = spi_cs_n; prev_sck = spi_sck;
    end
  end

  task automatic xfer(input logic [1:0] op, input logic [15:0] addr, input int len,
                      input bit pz, input bit thr, input bit keep);
    int cnt;
    cnt = (op[1] || len == 0) ? 1 : len;
    if (!keep) for (int i = 0; i < cnt; i++) wq[i] = 8'($urandom);
    wn = (op == 2'd1 || op == 2'd3) ? cnt : 0;
    widx = 0; rn = 0; throttle = thr; pause_en = pz;
    req_op = op; req_addr = addr; req_len = 16'(len); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    while (!done) @(negedge clk);
    pause_en = 0;
    chk(cap_op == exp_cmd(op), "R1 command byte", cap_op, exp_cmd(op));
    chk(nbytes == cnt, "R5/R6 data byte count", nbytes, cnt);
    if (!op[1]) chk(cap_addr == {1'b0, addr[14:0]}, "R2 address", cap_addr, {1'b0, addr[14:0]});
    if (op == 2'd1)
      for (int i = 0; i < cnt; i++) begin
        shadow[(int'(addr) + i) % 1024] = wq[i];
        chk(mem[(int'(addr) + i) % 1024] == wq[i], "R5 written byte", mem[(int'(addr) + i) % 1024], wq[i]);
      end
    if (op == 2'd0) begin
      chk(rn == cnt, "R3 read strobes", rn, cnt);
      for (int i = 0; i < cnt && i < rn; i++)
        chk(rq[i] == shadow[(int'(addr) + i) % 1024], "R3 read byte", rq[i], shadow[(int'(addr) + i) % 1024]);
    end
    if (op == 2'd3) begin
      sreg_exp = wq[0] & 8'hC1;
      chk(sreg == sreg_exp, "R6 status write masked", sreg, sreg_exp);
    end
    if (op == 2'd2) chk(rn == 1 && rq[0] == sreg_exp, "R6 status read", rq[0], sreg_exp);
    if (!pz) begin
      chk(first_dly == HD, "R4 cs to first rise", first_dly, HD);
      chk(first_hi == HD, "R4 high half period", first_hi, HD);
    end
  endtask

  initial begin
    repeat (1500) @(posedge clk);
    repeat (148500) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int i = 0; i < 1024; i++) begin mem[i] = 8'(i * 7 + 3); shadow[i] = 8'(i * 7 + 3); end
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0 && spi_hold_n == 1'b1, "R10 bus idle",
        {spi_cs_n, spi_sck, spi_hold_n}, 3'b101);
    chk(!busy && !done && !rd_valid && !wr_ready && req_ready, "R10 handshake idle",
        {busy, done, rd_valid, wr_ready, req_ready}, 5'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    xfer(2'd2, 16'h0000, 5, 0, 0, 0);
    wq[0] = 8'hFF;
    xfer(2'd3, 16'h0000, 9, 0, 0, 1);
    xfer(2'd2, 16'h1234, 0, 0, 0, 0);
    xfer(2'd1, 16'h8010, 1, 0, 0, 0);
    xfer(2'd0, 16'h8010, 1, 0, 0, 0);
    xfer(2'd1, 16'h0123, 0, 0, 0, 0);
    xfer(2'd0, 16'h0123, 0, 0, 0, 0);
    xfer(2'd1, 16'h7FFE, 4, 0, 1, 0);
    xfer(2'd0, 16'hFFFE, 4, 0, 0, 0);
    xfer(2'd1, 16'h0200, 12, 1, 1, 0);
    xfer(2'd0, 16'h0200, 12, 1, 0, 0);
    for (int n = 0; n < 40; n++)
      xfer(2'($urandom % 4), 16'($urandom), int'($urandom % 9),
           ($urandom % 3) == 0, ($urandom % 2) == 1, 0);
    chk(hold_edges == 0, "R7 no edges while paused", hold_edges, 0);
    chk(hold_bad == 0, "R7 pause changes at low clock", hold_bad, 0);
    chk(holds > 0, "R7 pause exercised", holds, 1);
    chk(gap_bad == 0, "R8 chip select gap", gap_bad, 0);
    chk(done_bad == 0, "R9 done with cs rise", done_bad, 0);
    chk(busy_bad == 0, "R9 busy tracks cs", busy_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule